// File: doc/BRIEF.md
# SPI Status Read Sequencer

This block is a master-side engine that performs one complete status-register read on a serial flash device over a four-wire SPI link. A single-cycle start request makes it assert the active-low select while the serial clock is still high, shift out the fixed 8-bit read-status opcode, and clock in the one-byte reply. The byte appears on a parallel output together with a one-cycle completion strobe. Only this one transaction is supported. Addresses, payloads, other opcodes and repeated polling are left to the surrounding logic.

The serial clock comes from the system clock through a divide-by-`DIV` ratio, where `DIV` must be even and at least 2. The serial clock rests high between transactions. Outgoing bits change on its falling edges. Incoming bits are captured on its rising edges. The select line is released half a serial period after the final rising edge, so the last reply bit is always captured before the device is deselected.

Top module: `spi_status_reader`

## Requirements
- R1: The opcode 0xD7 is sent most-significant bit first on `ser_dout`. `ser_dout` changes only in the system cycle in which `ser_clk` goes low, so it is stable at every rising edge of `ser_clk`.
- R2: When `busy` is low, `ser_sel_n` and `ser_clk` are both high. A transaction starts by pulling `ser_sel_n` low while `ser_clk` is high. The first falling edge of `ser_clk` follows DIV/2 system cycles later.
- R3: While `ser_sel_n` is low there are exactly 16 rising edges of `ser_clk`, and `ser_sel_n` stays low between them.
- R4: `ser_din` is sampled at rising edges 9 to 16. The first of these samples is the most-significant bit. The resulting byte is shown on `status_out` in the cycle in which `done` is high, and it is held until the next completion.
- R5: `ser_sel_n` returns high DIV/2 system cycles after the 16th rising edge, in the same cycle in which `done` rises, with `ser_clk` high.
- R6: `done` is high for exactly one system cycle per transaction. `busy` is high for exactly 33*DIV/2 system cycles, starting with the cycle after the accepted start.
- R7: A `start` that arrives while `busy` is high is ignored. It neither restarts nor extends the current transaction, and it does not begin a new one afterwards.
- R8: Each low phase and each high phase of `ser_clk` during a transaction lasts exactly DIV/2 system cycles.
- R9: After reset, `busy` and `done` are low and `ser_sel_n` and `ser_clk` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request one status read (accepted only when idle) |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion strobe |
| status_out | output | 8 | Last status byte received |
| ser_sel_n | output | 1 | Active-low device select |
| ser_clk | output | 1 | Serial clock, idles high |
| ser_dout | output | 1 | Serial data to the device |
| ser_din | input | 1 | Serial data from the device |

## Verification
A device model answers with status bytes that include the all-zeros, all-ones, single-top-bit and single-bottom-bit patterns. These show whether the capture order and the edge alignment are right. A wrong bit order or a capture one edge off gives a different byte. Random bytes from a seeded generator cover the remaining patterns. Some transactions get an extra start pulse partway through, to show that a request during a busy period is dropped rather than queued. Each transaction also measures the serial clock phase widths, the lead time from select to the first falling edge, and the busy length, so that errors in the divider and sequencing are caught.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
   localparam logic [7:0] STATUS_READ_CMD = 8'hD7;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LEAD,
      ST_LOW,
      ST_HIGH
   } seq_state_t;
endpackage

// File: rtl/spi_stat_timer.sv
module spi_stat_timer #(
   parameter int HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic seg_end
);
   generate
      if (HALF < 1) begin : g_bad_half
         $error("spi_stat_timer: HALF must be at least 1");
      end
      if (HALF == 1) begin : g_direct
         logic unused_tie;
         assign unused_tie = clk ^ rst_n;
         assign seg_end = run;
      end else begin : g_count
         localparam int CW = $clog2(HALF);
         localparam logic [CW-1:0] LAST = CW'(HALF - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt <= '0;
            end else if (!run || cnt == LAST) begin
               cnt <= '0;
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
         assign seg_end = run && (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/spi_stat_shift.sv
module spi_stat_shift #(
   parameter int CMD_W = 8,
   parameter int STAT_W = 8,
   parameter logic [CMD_W-1:0] CMD = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              fall_en,
   input  logic              rise_en,
   input  logic              din,
   output logic              dout,
   output logic [STAT_W-1:0] rx_word
);
   localparam int FRAME = CMD_W + STAT_W;

   logic [FRAME-1:0] txq;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txq  <= '0;
         dout <= 1'b0;
      end else if (load) begin
         txq <= {CMD, {STAT_W{1'b0}}};
      end else if (fall_en) begin
         dout <= txq[FRAME-1];
         txq  <= {txq[FRAME-2:0], 1'b0};
      end
   end

   generate
      if (STAT_W == 1) begin : g_rx_bit
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rx_word <= '0;
            else if (rise_en) rx_word <= din;
         end
      end else begin : g_rx_vec
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rx_word <= '0;
            else if (rise_en) rx_word <= {rx_word[STAT_W-2:0], din};
         end
      end
   endgenerate
endmodule

// File: rtl/spi_status_reader.sv
module spi_status_reader #(
   parameter int DIV = 4,
   parameter int CMD_W = 8,
   parameter int STAT_W = 8,
   parameter logic [CMD_W-1:0] CMD_CODE = spi_stat_pkg::STATUS_READ_CMD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   output logic              busy,
   output logic              done,
   output logic [STAT_W-1:0] status_out,
   output logic              ser_sel_n,
   output logic              ser_clk,
   output logic              ser_dout,
   input  logic              ser_din
);
   import spi_stat_pkg::*;

   localparam int HALF  = DIV / 2;
   localparam int FRAME = CMD_W + STAT_W;
   localparam int BCW   = $clog2(FRAME + 1);
   localparam logic [BCW-1:0] LAST_BIT = BCW'(FRAME);

   generate
      if (DIV < 2 || (DIV % 2) != 0) begin : g_bad_div
         $error("spi_status_reader: DIV must be even and at least 2");
      end
      if (CMD_W < 1 || STAT_W < 1) begin : g_bad_width
         $error("spi_status_reader: CMD_W and STAT_W must be positive");
      end
   endgenerate

   seq_state_t        state;
   logic [BCW-1:0]    bit_cnt;
   logic              seg_end;
   logic              load;
   logic              fall_en;
   logic              rise_en;
   logic              final_bit;
   logic [STAT_W-1:0] rx_word;

   assign busy      = (state != ST_IDLE);
   assign final_bit = (bit_cnt == LAST_BIT);
   assign load      = (state == ST_IDLE) && start;
   assign rise_en   = seg_end && (state == ST_LOW);
   assign fall_en   = seg_end && ((state == ST_LEAD) ||
                                  ((state == ST_HIGH) && !final_bit));

   spi_stat_timer #(.HALF(HALF)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .seg_end (seg_end)
   );

   spi_stat_shift #(
      .CMD_W  (CMD_W),
      .STAT_W (STAT_W),
      .CMD    (CMD_CODE)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (load),
      .fall_en (fall_en),
      .rise_en (rise_en),
      .din     (ser_din),
      .dout    (ser_dout),
      .rx_word (rx_word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         bit_cnt    <= '0;
         ser_sel_n  <= 1'b1;
         ser_clk    <= 1'b1;
         done       <= 1'b0;
         status_out <= '0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  state     <= ST_LEAD;
                  bit_cnt   <= '0;
                  ser_sel_n <= 1'b0;
               end
            end
            ST_LEAD: begin
               if (seg_end) begin
                  state   <= ST_LOW;
                  ser_clk <= 1'b0;
               end
            end
            ST_LOW: begin
               if (seg_end) begin
                  state   <= ST_HIGH;
                  ser_clk <= 1'b1;
                  bit_cnt <= bit_cnt + 1'b1;
               end
            end
            ST_HIGH: begin
               if (seg_end) begin
                  if (final_bit) begin
                     state      <= ST_IDLE;
                     ser_sel_n  <= 1'b1;
                     done       <= 1'b1;
                     status_out <= rx_word;
                  end else begin
                     state   <= ST_LOW;
                     ser_clk <= 1'b0;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/spi_stat_chk.sv
module spi_stat_chk #(
   parameter int DIV = 4
) (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic ser_sel_n,
   input logic ser_clk,
   input logic ser_dout
);
   localparam int HALF = DIV / 2;
   localparam int RW   = $clog2(DIV + 1) + 2;
   localparam logic [RW-1:0] HALF_V = RW'(HALF);

   logic          prev_clk;
   logic          prev_sel;
   logic [RW-1:0] run_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_clk <= 1'b1;
         prev_sel <= 1'b1;
         run_len  <= '0;
      end else begin
         prev_clk <= ser_clk;
         prev_sel <= ser_sel_n;
         if (ser_clk != prev_clk || ser_sel_n != prev_sel) run_len <= RW'(1);
         else if (run_len != '1) run_len <= run_len + 1'b1;
      end
   end

   // R9
   idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (ser_sel_n && ser_clk));

   // R2
   sel_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_sel_n) |-> (ser_clk && $past(!busy)));

   // R5
   sel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_sel_n) |-> (ser_clk && done));

   // R6
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R1
   dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_dout) |-> (!ser_clk && !ser_sel_n));

   // R3
   sel_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_sel_n |-> busy);

   // R8
   clk_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((ser_clk != prev_clk) && !ser_sel_n) |-> (run_len == HALF_V));
endmodule

bind spi_status_reader spi_stat_chk #(.DIV(DIV)) u_stat_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .done      (done),
   .ser_sel_n (ser_sel_n),
   .ser_clk   (ser_clk),
   .ser_dout  (ser_dout)
);

// File: tb/test_spi_status_reader.sv
`timescale 1ns/1ps
module test_spi_status_reader;
   localparam int DIV  = 4;
   localparam int HALF = DIV / 2;
   localparam realtime TCLK = 10.0;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       busy, done;
   logic [7:0] status_out;
   logic       ser_sel_n, ser_clk, ser_dout;
   logic       din_q = 1'b1;

   int n_checks = 0;
   int n_fail = 0;

   always #(TCLK/2) clk = ~clk;

   spi_status_reader #(.DIV(DIV)) i_spi_status_reader (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .busy       (busy),
      .done       (done),
      .status_out (status_out),
      .ser_sel_n  (ser_sel_n),
      .ser_clk    (ser_clk),
      .ser_dout   (ser_dout),
      .ser_din    (din_q)
   );

   // device model
   logic [7:0]  dev_status = 8'h00;
   logic [15:0] dev_rx;
   int          dev_rise, dev_fall, dev_sel_fall_count;
   bit          dev_width_bad, dev_sel_bad;
   realtime     t_edge;

   always @(negedge ser_sel_n) begin
      dev_rise = 0; dev_fall = 0; dev_rx = '0;
      dev_sel_fall_count++;
      if (!ser_clk) dev_sel_bad = 1;
      t_edge = $realtime;
   end
   always @(posedge ser_sel_n) din_q = 1'b1;
   always @(posedge ser_clk) if (!ser_sel_n) begin
      dev_rx = {dev_rx[14:0], ser_dout};
      dev_rise++;
      if ($realtime - t_edge != HALF * TCLK) dev_width_bad = 1;
      t_edge = $realtime;
   end
   always @(negedge ser_clk) if (!ser_sel_n) begin
      if ($realtime - t_edge != HALF * TCLK) dev_width_bad = 1;
      t_edge = $realtime;
      if (dev_fall >= 8) din_q = dev_status[15 - dev_fall];
      dev_fall++;
   end

   function automatic int exp_busy_len(int half);
      return 33 * half;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic run_txn(logic [7:0] st, bit extra_start);
      int busy_cycles = 0;
      int guard = 0;
      int sel_before;
      dev_status = st;
      dev_width_bad = 0;
      dev_sel_bad = 0;
      sel_before = dev_sel_fall_count;
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done && guard < 2000) begin
         if (busy) busy_cycles++;
         if (extra_start && busy_cycles == 10) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
         guard++;
      end
      start = 1'b0;
      check(done == 1'b1, "R6", "done seen", done, 1);
      check(status_out == st, "R4", "status byte", status_out, st);
      check(dev_rx[15:8] == 8'hD7, "R1", "opcode received", dev_rx[15:8], 8'hD7);
      check(dev_rise == 16, "R3", "rising edges", dev_rise, 16);
      check(ser_sel_n == 1'b1 && busy == 1'b0, "R5", "deselect at done",
            {ser_sel_n, busy}, 2'b10);
      check(busy_cycles == exp_busy_len(HALF), "R6", "busy length",
            busy_cycles, exp_busy_len(HALF));
      check(!dev_width_bad, "R8", "clock phase widths", dev_width_bad, 0);
      check(!dev_sel_bad, "R2", "select with clock high", dev_sel_bad, 0);
      @(negedge clk);
      check(done == 1'b0, "R6", "done one cycle", done, 0);
      if (extra_start) begin
         repeat (3 * DIV) @(negedge clk);
         check(busy == 1'b0 && dev_sel_fall_count == sel_before + 1, "R7",
               "start while busy ignored", dev_sel_fall_count - sel_before, 1);
         check(status_out == st, "R7", "status held", status_out, st);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks + 1, n_fail);
      $finish;
   end

   initial begin : stim
      process::self().srandom(32'h5EED_0042);
      repeat (3) @(negedge clk);
      check(busy == 0 && done == 0 && ser_sel_n == 1 && ser_clk == 1, "R9",
            "reset state", {busy, done, ser_sel_n, ser_clk}, 4'b0011);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check(busy == 0 && ser_sel_n == 1 && ser_clk == 1, "R9", "idle after reset",
            {busy, ser_sel_n, ser_clk}, 3'b011);
      run_txn(8'h00, 1'b0);
      run_txn(8'hFF, 1'b0);
      run_txn(8'h80, 1'b1);
      run_txn(8'h01, 1'b0);
      for (int i = 0; i < 12; i++) begin
         run_txn(8'($urandom), 1'($urandom_range(0, 1)));
         repeat ($urandom_range(0, 5)) @(negedge clk);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end
endmodule